// File: doc/BRIEF.md
# Sleep Mode Clock-Enable Controller

This block decides, for a small microcontroller, which parts of the chip keep their clock. The CPU writes a control register that holds an idle-request bit and a deep-sleep-request bit. The block turns those bits into three registered enables: one for the CPU core clock, one for the peripheral clock (timers, serial port, interrupt logic) and one for the oscillator. It also drives a RAM write lock that holds internal RAM contents while the chip is asleep, and a restart indication with the restart address.

There are two sleep depths. In idle, the CPU clock stops and the peripherals keep running. Any interrupt that is both requested and enabled brings the CPU back one cycle later, and hardware clears the idle bit. In deep sleep, the oscillator stops and everything is frozen. Interrupts have no effect, and only a hardware reset leaves this state, with execution restarting at address zero. A mode begins one clock after the register write that requests it, so the writing instruction completes first.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: During reset and after its release, `ctrl_q` is 0, `mode` is 0 (run), and `cpu_clk_en`, `per_clk_en` and `osc_en` are all 1 while `ram_lock` is 0. `restart_pc` always equals the restart vector, which defaults to 0.
- R2: In run mode (`mode`=0), a cycle with `wr_en` high loads `wr_data` into `ctrl_q` at the next clock edge. In idle or deep sleep, writes leave `ctrl_q` unchanged.
- R3: The idle request is bit 0 of the control register. Suppose bit 0 is set and bit 1 is clear in run mode. Then at the next edge `mode` becomes 1, `cpu_clk_en` goes to 0, and `per_clk_en` and `osc_en` stay at 1.
- R4: The deep-sleep request is bit 1 of the control register. When bit 1 is set in run mode, at the next edge `mode` becomes 2, all three enables go to 0 and `ram_lock` goes to 1.
- R5: When bits 0 and 1 are both set, deep sleep wins: `mode` becomes 2.
- R6: In idle, if any bit i has both `irq_req[i]` and `irq_en[i]` high, then at the next edge `mode` returns to 0 and `cpu_clk_en` returns to 1. At that same edge, bit 0 of `ctrl_q` clears while the other bits keep their value.
- R7: In idle, requested interrupts whose `irq_en` bit is 0 do not wake the block, and `mode` stays 1.
- R8: In deep sleep, interrupts have no effect, whether enabled or not. `mode`, the enables and `ctrl_q` hold their values.
- R9: A hardware reset leaves either sleep mode. `restart` is 1 after every edge at which `rst` is high, and it falls at the first edge at which `rst` is low. After that edge the block is in run mode with all enables at 1, `ctrl_q` is 0 and `restart_pc` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | CPU write strobe for the control register |
| wr_data | input | CTRL_W (8) | Value to write; bit 0 requests idle, bit 1 requests deep sleep |
| irq_req | input | N_IRQ (5) | Interrupt request lines |
| irq_en | input | N_IRQ (5) | Per-source interrupt enable |
| ctrl_q | output | CTRL_W (8) | Current control register value |
| mode | output | 2 | 0 run, 1 idle, 2 deep sleep |
| cpu_clk_en | output | 1 | CPU core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| ram_lock | output | 1 | Blocks internal RAM writes so contents are held |
| restart | output | 1 | Restart indication, high from reset until the first edge after its release |
| restart_pc | output | PC_W (16) | Address at which execution restarts |

## Verification
A write to the control register shows in `ctrl_q` after the first clock edge. The requested mode, together with its enables and RAM lock, follows one edge after that. An enabled interrupt in idle takes effect at the first edge at which it is present, and `restart` follows `rst` with a delay of one edge. The bench drives every input 2 ns after a rising edge. It advances exactly the number of edges listed above, then samples 2 ns after the edge at which the result is due. For each "no effect" case it holds the stimulus for several edges and checks at each one.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pm_mode_e;

  typedef struct packed {
    logic cpu;
    logic per;
    logic osc;
    logic lock;
  } pm_en_t;

  function automatic pm_en_t pm_enables(input pm_mode_e m);
    pm_en_t e;
    case (m)
      PM_IDLE: e = '{cpu: 1'b0, per: 1'b1, osc: 1'b1, lock: 1'b0};
      PM_DOWN: e = '{cpu: 1'b0, per: 1'b0, osc: 1'b0, lock: 1'b1};
      default: e = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, lock: 1'b0};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg #(
  parameter int CTRL_W   = 8,
  parameter int IDLE_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              clr_idle,
  output logic [CTRL_W-1:0] ctrl_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ok)
        ctrl_q <= wr_data;
      if (clr_idle)
        ctrl_q[IDLE_BIT] <= 1'b0;
    end
  end

endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int N_IRQ = 5
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             wake_any
);

  logic [N_IRQ-1:0] live;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    assign live[i] = irq_req[i] & irq_en[i];
  end

  assign wake_any = |live;

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     idle_req,
  input  logic     down_req,
  input  logic     wake_any,
  output pm_mode_e mode_q,
  output pm_mode_e mode_nxt,
  output logic     clr_idle
);

  always_comb begin
    mode_nxt = mode_q;
    clr_idle = 1'b0;
    case (mode_q)
      PM_RUN: begin
        if (down_req)
          mode_nxt = PM_DOWN;
        else if (idle_req)
          mode_nxt = PM_IDLE;
      end
      PM_IDLE: begin
        if (wake_any) begin
          mode_nxt = PM_RUN;
          clr_idle = 1'b1;
        end
      end
      PM_DOWN: mode_nxt = PM_DOWN;
      default: mode_nxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= PM_RUN;
    else
      mode_q <= mode_nxt;
  end

endmodule

// File: rtl/pwr_enable_gen.sv
module pwr_enable_gen
  import pwr_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pm_mode_e mode_nxt,
  output logic     cpu_clk_en,
  output logic     per_clk_en,
  output logic     osc_en,
  output logic     ram_lock,
  output logic     restart
);

  pm_en_t en_nxt;

  assign en_nxt = pm_enables(mode_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
      osc_en     <= 1'b1;
      ram_lock   <= 1'b0;
      restart    <= 1'b1;
    end else begin
      cpu_clk_en <= en_nxt.cpu;
      per_clk_en <= en_nxt.per;
      osc_en     <= en_nxt.osc;
      ram_lock   <= en_nxt.lock;
      restart    <= 1'b0;
    end
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int              CTRL_W    = 8,
  parameter int              IDLE_BIT  = 0,
  parameter int              DOWN_BIT  = 1,
  parameter int              N_IRQ     = 5,
  parameter int              PC_W      = 16,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [N_IRQ-1:0]  irq_en,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [1:0]        mode,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              ram_lock,
  output logic              restart,
  output logic [PC_W-1:0]   restart_pc
);

  pm_mode_e mode_q;
  pm_mode_e mode_nxt;
  logic     clr_idle;
  logic     wake_any;
  logic     wr_ok;

  // the CPU can only issue writes while its clock runs
  assign wr_ok = wr_en && (mode_q == PM_RUN);

  pwr_ctrl_reg #(
    .CTRL_W   (CTRL_W),
    .IDLE_BIT (IDLE_BIT)
  ) u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_ok    (wr_ok),
    .wr_data  (wr_data),
    .clr_idle (clr_idle),
    .ctrl_q   (ctrl_q)
  );

  pwr_wake_detect #(
    .N_IRQ (N_IRQ)
  ) u_wake (
    .irq_req  (irq_req),
    .irq_en   (irq_en),
    .wake_any (wake_any)
  );

  pwr_mode_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .idle_req (ctrl_q[IDLE_BIT]),
    .down_req (ctrl_q[DOWN_BIT]),
    .wake_any (wake_any),
    .mode_q   (mode_q),
    .mode_nxt (mode_nxt),
    .clr_idle (clr_idle)
  );

  pwr_enable_gen u_en (
    .clk        (clk),
    .rst        (rst),
    .mode_nxt   (mode_nxt),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en),
    .ram_lock   (ram_lock),
    .restart    (restart)
  );

  assign mode       = mode_q;
  assign restart_pc = RESET_VEC;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
  import pwr_mode_pkg::*;
#(
  parameter int CTRL_W   = 8,
  parameter int IDLE_BIT = 0,
  parameter int DOWN_BIT = 1,
  parameter int N_IRQ    = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [N_IRQ-1:0]  irq_req,
  input logic [N_IRQ-1:0]  irq_en,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [1:0]        mode,
  input logic              cpu_clk_en,
  input logic              per_clk_en,
  input logic              osc_en,
  input logic              ram_lock,
  input logic              restart
);

  logic wake;
  assign wake = |(irq_req & irq_en);

  p_idle_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_RUN && ctrl_q[IDLE_BIT] && !ctrl_q[DOWN_BIT]) |=> (mode == PM_IDLE));

  p_idle_enables_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_IDLE) |-> (!cpu_clk_en && per_clk_en && osc_en && !ram_lock));

  p_down_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_RUN && ctrl_q[DOWN_BIT]) |=> (mode == PM_DOWN));

  p_down_enables_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_DOWN) |-> (!cpu_clk_en && !per_clk_en && !osc_en && ram_lock));

  p_idle_wake_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_IDLE && wake) |=> (mode == PM_RUN && cpu_clk_en && !ctrl_q[IDLE_BIT]));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_IDLE && !wake) |=> (mode == PM_IDLE));

  p_down_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_DOWN) |=> (mode == PM_DOWN && $stable(ctrl_q)));

  p_restart_r9: assert property (@(posedge clk)
    rst |=> restart);

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
  .CTRL_W   (CTRL_W),
  .IDLE_BIT (IDLE_BIT),
  .DOWN_BIT (DOWN_BIT),
  .N_IRQ    (N_IRQ)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_req    (irq_req),
  .irq_en     (irq_en),
  .ctrl_q     (ctrl_q),
  .mode       (mode),
  .cpu_clk_en (cpu_clk_en),
  .per_clk_en (per_clk_en),
  .osc_en     (osc_en),
  .ram_lock   (ram_lock),
  .restart    (restart)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [4:0]  irq_req = '0;
  logic [4:0]  irq_en = '0;
  logic [7:0]  ctrl_q;
  logic [1:0]  mode;
  logic        cpu_clk_en, per_clk_en, osc_en, ram_lock, restart;
  logic [15:0] restart_pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .irq_req(irq_req), .irq_en(irq_en), .ctrl_q(ctrl_q), .mode(mode),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .ram_lock(ram_lock), .restart(restart), .restart_pc(restart_pc)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode, cpu, per, osc, lock packed as a 6-bit word
  function automatic int pack_state();
    return {mode, cpu_clk_en, per_clk_en, osc_en, ram_lock};
  endfunction

  task automatic write_ctrl(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    check("R9 restart in reset", restart, 1);
    rst = 1'b0;
    step();
    check("R1 reset ctrl", ctrl_q, 0);
    check("R1 reset state", pack_state(), 6'b00_1110);
    check("R1 restart_pc", restart_pc, 0);
    check("R9 restart falls", restart, 0);
  endtask

  task automatic t_write();
    write_ctrl(8'hA4);
    check("R2 write load", ctrl_q, 8'hA4);
    step();
    check("R2 no mode from other bits", pack_state(), 6'b00_1110);
    write_ctrl(8'h00);
    check("R2 write clear", ctrl_q, 0);
  endtask

  task automatic t_idle_wake();
    write_ctrl(8'hA1);
    check("R2 idle write", ctrl_q, 8'hA1);
    check("R3 not yet idle", mode, 0);
    step();
    check("R3 idle state", pack_state(), 6'b01_0110);
    irq_en = 5'b00100;
    irq_req = 5'b00100;
    step();
    check("R6 wake state", pack_state(), 6'b00_1110);
    check("R6 idle bit cleared", ctrl_q, 8'hA0);
    irq_req = '0;
    irq_en = '0;
    step();
    check("R6 stays run", mode, 0);
  endtask

  task automatic t_idle_masked();
    write_ctrl(8'h01);
    step();
    check("R3 idle again", mode, 1);
    irq_req = 5'b11011;
    irq_en = 5'b00100;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R7 masked irq no wake", pack_state(), 6'b01_0110);
    end
    write_ctrl(8'h00);
    check("R2 write ignored in idle", ctrl_q, 8'h01);
    irq_en = 5'b10000;
    step();
    check("R6 wake top source", mode, 0);
    check("R6 ctrl after wake", ctrl_q, 8'h00);
    irq_req = '0;
    irq_en = '0;
  endtask

  task automatic t_down();
    write_ctrl(8'h02);
    step();
    check("R4 down state", pack_state(), 6'b10_0001);
    irq_req = 5'b11111;
    irq_en = 5'b11111;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R8 irq ignored in down", pack_state(), 6'b10_0001);
    end
    write_ctrl(8'h00);
    check("R8 ctrl held in down", ctrl_q, 8'h02);
    irq_req = '0;
    irq_en = '0;
    rst = 1'b1;
    step();
    check("R9 restart asserted", restart, 1);
    check("R9 enables back", pack_state(), 6'b00_1110);
    rst = 1'b0;
    step();
    check("R9 restart done", restart, 0);
    check("R9 ctrl cleared", ctrl_q, 0);
    check("R9 restart_pc zero", restart_pc, 0);
  endtask

  task automatic t_both();
    write_ctrl(8'h03);
    step();
    check("R5 both bits pick down", pack_state(), 6'b10_0001);
    rst = 1'b1;
    step();
    rst = 1'b0;
    step();
    check("R9 leave down via reset", mode, 0);
  endtask

  task automatic t_idle_reset();
    write_ctrl(8'h01);
    step();
    check("R3 idle before reset", mode, 1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    step();
    check("R9 idle left by reset", pack_state(), 6'b00_1110);
    check("R9 ctrl after idle reset", ctrl_q, 0);
  endtask

  initial begin
    #1;
    t_reset();
    t_write();
    t_idle_wake();
    t_idle_masked();
    t_down();
    t_both();
    t_idle_reset();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule